// File: doc/BRIEF.md
# Flash Dummy-Byte Inserter for Software-Driven Transfers

This block sits beside the serial shifter of a flash controller while software drives a transfer byte by byte. After the chip select is asserted it watches the bytes software writes. The first write carries the command opcode. A fixed table tells the block how many dummy units that command needs. It then counts the address bytes as they go past. When software makes the next write after the address phase, the block puts the required dummy bytes out to the shifter itself, using a programmable fill byte, and swallows that write. Software therefore never has to know the dummy length of a command.

Commands that need no dummy bytes, opcodes missing from the table, and any transfer outside software-driven mode switch the inserter off. In all those cases every write passes through unchanged. While dummy bytes are going out, the write port holds its ready signal low, so the triggering write finishes only after the last dummy byte has been taken.

Top module: `snp_dummy_snooper`

## Requirements
- R1: After reset the inserter is off: `wr_ready` is 1, `dummy_valid` is 0, and writes are accepted with `wr_suppress` = 0.
- R2: A rising edge on `cs_active` arms the inserter. The first write accepted in a later cycle is decoded as the opcode, and the byte count restarts from zero. A falling edge on `cs_active` turns the inserter off and stops any dummy output.
- R3: The opcode is `wr_opcode`, the least significant write byte. The table gives 1 dummy unit for 0x0B, 0x3B, 0x6B, 0x3C and 0x6C. It gives 2 units for 0xBB, 0x0C and 0xBC, and 4 units for 0xEB and 0xEC.
- R4: For opcodes 0x03, 0x02, 0xA2, 0x32, 0x13, 0x12 and 0x34, and for any opcode not in the table, the inserter turns off. The opcode write and all later writes pass through, and no dummy byte is produced.
- R5: The number of dummy bytes produced equals the dummy units × 8. Every dummy byte carries the `fill_byte` value sampled when the dummy phase starts.
- R6: The address width is 4 bytes when `addr4` = 1 and 3 bytes when it is 0. The dummy phase starts on the first write made once the byte count has reached address width + 1.
- R7: Each accepted write before the dummy phase advances the byte count by `wr_size`, which is the byte count 1 to 4 in binary. Those writes pass with `wr_suppress` = 0.
- R8: The write that starts the dummy phase is accepted with `wr_suppress` = 1. The inserter then turns off, and later writes pass through.
- R9: From the cycle the dummy phase is detected until the last dummy byte has been accepted, `wr_ready` stays 0. A dummy byte that is not accepted stays valid and does not change.
- R10: While `user_mode` is 0 the inserter stays off and produces no dummy bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| user_mode | input | 1 | Chip-select mode field is software-driven mode |
| cs_active | input | 1 | Chip select asserted (active high) |
| addr4 | input | 1 | 4-byte addressing enabled |
| fill_byte | input | 8 | Value placed on dummy bytes |
| wr_valid | input | 1 | Software write offered |
| wr_ready | output | 1 | Write accepted this cycle when valid |
| wr_opcode | input | 8 | Least significant byte of the write data |
| wr_size | input | 3 | Bytes in the write, 1 to 4 |
| wr_suppress | output | 1 | Accepted write is swallowed and not forwarded |
| dummy_valid | output | 1 | Dummy byte offered to the shifter |
| dummy_ready | input | 1 | Shifter takes the dummy byte |
| dummy_data | output | 8 | Dummy byte value |

## Verification
The bench sends every tabled opcode, several unknown ones, and the zero-dummy commands. An inserter that read the table wrongly would produce the wrong number of fill bytes, or would swallow a write for a command that needs none. Multi-byte writes during the address phase catch a byte count that advances by one per write instead of by the write size; such a design would trigger late and let the trigger write pass. Transfers with 3- and 4-byte addresses catch a threshold that is off by one. Dropping the chip select in the middle of the address phase and then raising it again catches a count that does not restart. Toggling the shifter's ready line catches dummy bytes that are lost or counted twice under backpressure. Turning the mode off catches an inserter that ignores the mode field.

// File: rtl/snp_pkg.sv
package snp_pkg;

    // Tracking states of the dummy-byte inserter
    typedef enum logic [2:0] {
        SNP_OFF    = 3'd0,
        SNP_ARMED  = 3'd1,
        SNP_TRACK  = 3'd2,
        SNP_EMIT   = 3'd3,
        SNP_FINISH = 3'd4
    } snp_state_e;

    // Dummy bytes per dummy unit
    localparam int unsigned SNP_UNIT_BYTES = 8;

    // Address bytes without and with extended addressing
    localparam int unsigned SNP_ADDR_NARROW = 3;
    localparam int unsigned SNP_ADDR_WIDE   = 4;

endpackage

// File: rtl/snp_opcode_lut.sv
module snp_opcode_lut #(
    parameter int unsigned UNIT_W = 3
) (
    input  logic [7:0]        opcode,
    output logic [UNIT_W-1:0] units
);

    // R3/R4: fixed opcode to dummy-unit table; zero means no insertion
    always_comb begin
        case (opcode)
            8'h0B, 8'h3B, 8'h6B, 8'h3C, 8'h6C: units = UNIT_W'(1);
            8'hBB, 8'h0C, 8'hBC:               units = UNIT_W'(2);
            8'hEB, 8'hEC:                      units = UNIT_W'(4);
            default:                           units = '0;
        endcase
    end

endmodule

// File: rtl/snp_dummy_emitter.sv
module snp_dummy_emitter #(
    parameter int unsigned CNT_W   = 6,
    parameter int unsigned MAX_CNT = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_count,
    input  logic [7:0]       fill,
    input  logic             abort,
    input  logic             dummy_ready,
    output logic             dummy_valid,
    output logic [7:0]       dummy_data,
    output logic             done
);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [7:0]       fill;
    } emit_t;

    emit_t em_d, em_q;

    always_comb begin
        em_d = em_q;
        if (abort) begin
            em_d.count = '0;
        end else if (load) begin
            em_d.count = load_count;
            em_d.fill  = fill;
        end else if (em_q.count != '0 && dummy_ready) begin
            em_d.count = em_q.count - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            em_q <= '0;
        end else begin
            em_q <= em_d;
        end
    end

    assign dummy_valid = (em_q.count != '0);
    assign dummy_data  = em_q.fill;
    assign done        = dummy_valid && dummy_ready && (em_q.count == CNT_W'(1));

    // R9: an offered dummy byte is held until taken
    a_r9_dummy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dummy_valid && !dummy_ready && !abort) |=> (dummy_valid && $stable(dummy_data)));

    // R5: the pending count never exceeds the largest table entry
    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        em_q.count <= CNT_W'(MAX_CNT));

endmodule

// File: rtl/snp_dummy_snooper.sv
module snp_dummy_snooper #(
    parameter int unsigned SIZE_W    = 3,
    parameter int unsigned UNIT_W    = 3,
    parameter int unsigned MAX_UNITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              user_mode,
    input  logic              cs_active,
    input  logic              addr4,
    input  logic [7:0]        fill_byte,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [7:0]        wr_opcode,
    input  logic [SIZE_W-1:0] wr_size,
    output logic              wr_suppress,
    output logic              dummy_valid,
    input  logic              dummy_ready,
    output logic [7:0]        dummy_data
);
    import snp_pkg::*;

    localparam int unsigned UNIT_SH = $clog2(SNP_UNIT_BYTES);
    localparam int unsigned CNT_W   = UNIT_W + UNIT_SH;
    localparam int unsigned MAX_CNT = MAX_UNITS * SNP_UNIT_BYTES;
    localparam int unsigned IDX_W   = $clog2(SNP_ADDR_WIDE + 1 + (1 << SIZE_W));

    typedef struct packed {
        snp_state_e       state;
        logic [IDX_W-1:0] idx;
        logic [CNT_W-1:0] pend;
        logic             cs;
    } trk_t;

    trk_t trk_d, trk_q;

    logic [UNIT_W-1:0] units;
    logic              em_load;
    logic              em_abort;
    logic              em_done;
    logic              cs_rise;
    logic              cs_fall;
    logic [IDX_W-1:0]  phase_at;

    snp_opcode_lut #(.UNIT_W(UNIT_W)) u_lut (
        .opcode (wr_opcode),
        .units  (units)
    );

    assign cs_rise  = cs_active && !trk_q.cs;
    assign cs_fall  = !cs_active && trk_q.cs;
    assign em_abort = cs_fall || !user_mode;
    assign phase_at = addr4 ? IDX_W'(SNP_ADDR_WIDE + 1) : IDX_W'(SNP_ADDR_NARROW + 1);

    always_comb begin
        trk_d       = trk_q;
        trk_d.cs    = cs_active;
        em_load     = 1'b0;
        wr_ready    = 1'b1;
        wr_suppress = 1'b0;

        case (trk_q.state)
            SNP_ARMED: begin
                if (wr_valid) begin
                    if (units == '0) begin
                        trk_d.state = SNP_OFF;
                    end else begin
                        trk_d.state = SNP_TRACK;
                        trk_d.pend  = {units, {UNIT_SH{1'b0}}};
                        trk_d.idx   = IDX_W'(wr_size);
                    end
                end
            end
            SNP_TRACK: begin
                if (wr_valid) begin
                    if (trk_q.idx >= phase_at) begin
                        wr_ready    = 1'b0;
                        em_load     = 1'b1;
                        trk_d.state = SNP_EMIT;
                    end else begin
                        trk_d.idx = trk_q.idx + IDX_W'(wr_size);
                    end
                end
            end
            SNP_EMIT: begin
                wr_ready = 1'b0;
                if (em_done) begin
                    trk_d.state = SNP_FINISH;
                end
            end
            SNP_FINISH: begin
                if (wr_valid) begin
                    wr_suppress = 1'b1;
                    trk_d.state = SNP_OFF;
                end
            end
            default: ;
        endcase

        // chip select edges and mode take priority over tracking
        if (em_abort) begin
            trk_d.state = SNP_OFF;
        end else if (cs_rise) begin
            trk_d.state = SNP_ARMED;
            trk_d.idx   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '{state: SNP_OFF, idx: '0, pend: '0, cs: 1'b0};
        end else begin
            trk_q <= trk_d;
        end
    end

    snp_dummy_emitter #(.CNT_W(CNT_W), .MAX_CNT(MAX_CNT)) u_emit (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (em_load && !em_abort),
        .load_count  (trk_q.pend),
        .fill        (fill_byte),
        .abort       (em_abort),
        .dummy_ready (dummy_ready),
        .dummy_valid (dummy_valid),
        .dummy_data  (dummy_data),
        .done        (em_done)
    );

    // R9: no write completes while a dummy byte is outstanding
    a_r9_ready_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        dummy_valid |-> !wr_ready);

    // R8: a swallowed write is always a completed handshake
    a_r8_suppress_handshake: assert property (@(posedge clk) disable iff (!rst_n)
        wr_suppress |-> (wr_valid && wr_ready));

    // R2: dropping chip select silences the dummy output
    a_r2_cs_fall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_active && trk_q.cs) |=> !dummy_valid);

    // R10: outside software-driven mode no dummy byte is offered
    a_r10_mode_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !user_mode |=> !dummy_valid);

    // R4: an opcode with no dummy units never starts insertion
    a_r4_zero_off: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_q.state == SNP_ARMED && wr_valid && units == '0) |=> !dummy_valid);

endmodule

// File: tb/tb_snp_dummy_snooper.sv
module tb_snp_dummy_snooper;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       user_mode = 1'b1;
    logic       cs_active = 1'b0;
    logic       addr4 = 1'b0;
    logic [7:0] fill_byte = 8'hA5;
    logic       wr_valid = 1'b0;
    logic       wr_ready;
    logic [7:0] wr_opcode = 8'h00;
    logic [2:0] wr_size = 3'd1;
    logic       wr_suppress;
    logic       dummy_valid;
    logic       dummy_ready = 1'b1;
    logic [7:0] dummy_data;

    int checks = 0;
    int fails = 0;
    int dummies_seen = 0;
    int dummy_bad = 0;
    bit stall_mode = 1'b0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    snp_dummy_snooper dut (
        .clk(clk), .rst_n(rst_n), .user_mode(user_mode), .cs_active(cs_active),
        .addr4(addr4), .fill_byte(fill_byte), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_opcode(wr_opcode), .wr_size(wr_size), .wr_suppress(wr_suppress),
        .dummy_valid(dummy_valid), .dummy_ready(dummy_ready), .dummy_data(dummy_data)
    );

    // shifter model: drive ready at the falling edge, count accepted bytes before the rising edge
    always begin
        @(negedge clk);
        dummy_ready = stall_mode ? ~dummy_ready : 1'b1;
        #3;
        if (dummy_valid && dummy_ready) begin
            dummies_seen++;
            if (dummy_data != fill_byte) dummy_bad++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_units(input logic [7:0] op);
        case (op)
            8'h0B, 8'h3B, 8'h6B, 8'h3C, 8'h6C: return 1;
            8'hBB, 8'h0C, 8'hBC:               return 2;
            8'hEB, 8'hEC:                      return 4;
            default:                           return 0;
        endcase
    endfunction

    task automatic wr(input logic [7:0] d, input int sz, output bit supp, output int stalls);
        @(negedge clk);
        wr_valid  = 1'b1;
        wr_opcode = d;
        wr_size   = 3'(sz);
        stalls    = 0;
        forever begin
            #3;
            if (wr_ready) begin
                supp = wr_suppress;
                break;
            end
            stalls++;
            @(negedge clk);
        end
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic cs_up();
        @(negedge clk);
        cs_active = 1'b1;
        @(negedge clk);
    endtask

    task automatic cs_down();
        @(negedge clk);
        cs_active = 1'b0;
        @(negedge clk);
    endtask

    // one full transfer: opcode write, address bytes, trigger write, one more write
    task automatic t_command(input logic [7:0] op, input bit a4, input int first_sz, input string tag);
        bit supp;
        int stalls;
        int sent;
        int aw;
        int n;
        addr4 = a4;
        aw = a4 ? 4 : 3;
        n = exp_units(op) * 8;
        cs_up();
        dummies_seen = 0;
        dummy_bad = 0;
        wr(op, first_sz, supp, stalls);
        chk({tag, " R7 opcode write passes"}, supp, 0);
        sent = first_sz;
        while (sent < aw + 1) begin
            wr(8'h5A, 1, supp, stalls);
            chk({tag, " R7 address write passes"}, supp, 0);
            sent++;
        end
        wr(8'h77, 1, supp, stalls);
        if (n == 0) begin
            chk({tag, " R4 write after address passes"}, supp, 0);
            chk({tag, " R4 no dummies"}, dummies_seen, 0);
        end else begin
            chk({tag, " R8 trigger write suppressed"}, supp, 1);
            chk({tag, " R5 dummy count"}, dummies_seen, n);
            chk({tag, " R5 dummy fill value errors"}, dummy_bad, 0);
            if (stall_mode) chk({tag, " R9 ready held low"}, int'(stalls >= n), 1);
            else chk({tag, " R9 ready low cycles"}, stalls, n + 1);
        end
        wr(8'h66, 1, supp, stalls);
        chk({tag, " R8 later write passes"}, supp, 0);
        chk({tag, " R8 no further dummies"}, dummies_seen, n);
        cs_down();
    endtask

    task automatic t_reset();
        bit supp;
        int stalls;
        chk("R1 ready after reset", wr_ready, 1);
        chk("R1 no dummy after reset", dummy_valid, 0);
        wr(8'h0B, 1, supp, stalls);
        chk("R1 write passes while idle", supp, 0);
        chk("R1 no stall while idle", stalls, 0);
    endtask

    task automatic t_table();
        logic [7:0] ops [17] = '{8'h0B, 8'h3B, 8'h6B, 8'h3C, 8'h6C, 8'hBB, 8'h0C, 8'hBC,
                                 8'hEB, 8'hEC, 8'h03, 8'h02, 8'hA2, 8'h32, 8'h13, 8'h12, 8'h34};
        for (int i = 0; i < 17; i++) begin
            t_command(ops[i], 1'b0, 1, "R3 table");
        end
        t_command(8'h9F, 1'b0, 1, "R4 unknown 9F");
        t_command(8'hFF, 1'b0, 1, "R4 unknown FF");
    endtask

    task automatic t_width();
        t_command(8'hEB, 1'b1, 1, "R6 wide address");
        t_command(8'h0C, 1'b0, 1, "R6 narrow address");
        t_command(8'hBC, 1'b1, 1, "R6 wide two units");
    endtask

    task automatic t_sizes();
        bit supp;
        int stalls;
        addr4 = 1'b0;
        cs_up();
        dummies_seen = 0;
        wr(8'h0B, 2, supp, stalls);
        chk("R7 two-byte opcode write passes", supp, 0);
        wr(8'h11, 2, supp, stalls);
        chk("R7 two-byte address write passes", supp, 0);
        wr(8'h22, 1, supp, stalls);
        chk("R7 trigger after sized writes", supp, 1);
        chk("R7 dummies after sized writes", dummies_seen, 8);
        cs_down();
        t_command(8'hBB, 1'b0, 4, "R7 four-byte opcode write");
    endtask

    task automatic t_cs_restart();
        bit supp;
        int stalls;
        addr4 = 1'b0;
        cs_up();
        dummies_seen = 0;
        wr(8'h0B, 1, supp, stalls);
        wr(8'h01, 1, supp, stalls);
        wr(8'h02, 1, supp, stalls);
        cs_down();
        chk("R2 no dummies after early drop", dummies_seen, 0);
        t_command(8'h0B, 1'b0, 1, "R2 restart after drop");
    endtask

    task automatic t_mode();
        bit supp;
        int stalls;
        user_mode = 1'b0;
        addr4 = 1'b0;
        cs_up();
        dummies_seen = 0;
        wr(8'hEB, 1, supp, stalls);
        for (int i = 0; i < 5; i++) begin
            wr(8'h40, 1, supp, stalls);
            chk("R10 write passes outside mode", supp, 0);
        end
        chk("R10 no dummies outside mode", dummies_seen, 0);
        cs_down();
        user_mode = 1'b1;
    endtask

    task automatic t_backpressure();
        fill_byte  = 8'h3C;
        stall_mode = 1'b1;
        t_command(8'hEB, 1'b0, 1, "R9 toggled shifter ready");
        stall_mode = 1'b0;
        fill_byte  = 8'hA5;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_table();
        t_width();
        t_sizes();
        t_cs_restart();
        t_mode();
        t_backpressure();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule